// File: doc/BRIEF.md
# Serial Flash Sector Erase Sequencer

This block turns a single user request into the serial-bus traffic that erases one sector of a serial NOR flash. The user holds an address anywhere inside the sector, then raises the write-enable qualifier together with the erase strobe. The block first reads the flash status byte and checks its block-protect field against the address. If the sector is writable, it sends a write-enable frame and then the erase frame with the address. It then reads the status byte again and again until the device reports that it is no longer busy.

The user side sees only `busy` and a short `illegalErase` pulse. The pulse marks a refusal because the sector is protected. After `busy` falls, two clock cycles pass before a new request is looked at. A request that is still held after that window starts another erase. The flash side is a single-bit SPI master in mode 0. The serial clock is the system clock divided by an even parameter.

Top module: `spiSectorEraser`

## Requirements
- R1: During and right after reset, `busy` and `illegalErase` are low, `spiCsN` is high and `spiSck` is low.
- R2: A request is taken only at a rising clock edge where `eraseReq` and `wrEn` are both high. `busy` is high from the cycle after that edge.
- R3: If `wrEn` is low whenever `eraseReq` is sampled (or the reverse), no frame appears on the bus and `busy` stays low.
- R4: An accepted request produces these frames, each in its own chip-select window, in this order:
  - status read, opcode 0x05, followed by 8 read bits;
  - write enable, opcode 0x06;
  - sector erase, opcode 0xD8, followed by the address most significant byte first.

  All bits are sent MSB first. The bus uses mode 0: `spiSck` idles low, data changes while the clock is low, and data is sampled on the rising edge. `spiCsN` is high whenever `busy` is low.
- R5: After the erase frame, the block repeats status reads (0x05) until status bit 0 reads 0. `busy` falls in the cycle after the last serial clock edge of the poll that read 0. With divider D, `busy` lasts (16D+1)+(8D+1)+((8+A)D+1)+P(16D+1) cycles, where A is the address width and P is the number of polls.
- R6: A protected request produces only the first status read. `busy` then falls after 16D+1 cycles, and `illegalErase` is high for exactly the two following cycles. It is never high together with `busy`.
- R7: The protection field is status bits 4:2, read as a number n. If n = 0, nothing is protected. Otherwise the top 2^(SECTOR_BITS+n-1) bytes of the 2^MEM_ADDR_BITS byte array are protected, or the whole array when that size exceeds it.
- R8: For two clock edges after `busy` falls, requests are ignored.
- R9: If `eraseReq` and `wrEn` are still high when the ignore window ends, a second erase starts.
- R10: With `ADDR_4B` set, `addr` is 32 bits wide and the erase frame carries four address bytes. Otherwise it carries three bytes from a 24-bit `addr`.
- R11: Inside a frame, `spiSck` has a period of exactly CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| eraseReq | input | 1 | Sector erase strobe |
| wrEn | input | 1 | Write-enable qualifier for the strobe |
| addr | input | 24 or 32 | Any byte address inside the target sector |
| busy | output | 1 | Erase sequence in progress |
| illegalErase | output | 1 | Two-cycle pulse when a protected sector is refused |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSck | output | 1 | Serial clock, idles low |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
The assertions watch the bus and handshake rules every cycle:
- `busy` rises only after a sampled request with `wrEn` high;
- chip select stays high and the serial clock low whenever nothing is in flight;
- data holds while the serial clock is high;
- the refusal pulse is exactly two cycles and follows a busy period;
- `busy` stays low through the ignore window.

Other behaviour can only be shown by the bench scenarios:
- whether protection is decoded correctly at the sector boundaries for several field values;
- whether the frames carry the right opcodes and address bytes;
- how many polls are made;
- whether a held request really starts a second erase.

A behavioural model of `busy` and `illegalErase` timing checks those scenarios against the port outputs every cycle, next to a flash model that decodes the traffic.

// File: rtl/spiErasePkg.sv
package spiErasePkg;

  localparam logic [7:0] OP_READ_STATUS = 8'h05;
  localparam logic [7:0] OP_WRITE_EN    = 8'h06;
  localparam logic [7:0] OP_SECT_ERASE  = 8'hD8;

  typedef enum logic [1:0] {
    FR_STATUS = 2'd0,
    FR_WREN   = 2'd1,
    FR_ERASE  = 2'd2
  } frameKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       latchAddr;
    logic       start;
    frameKind_t kind;
  } dpCmd_t;

  // flags from datapath back to control
  typedef struct packed {
    logic frameDone;
    logic wip;
    logic protHit;
  } dpStat_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RDSR,
    ST_CHECK,
    ST_WREN,
    ST_WREN_WAIT,
    ST_ERASE,
    ST_ERASE_WAIT,
    ST_POLL,
    ST_POLL_WAIT,
    ST_COOL,
    ST_REFUSE
  } seqState_t;

endpackage

// File: rtl/eraseDatapath.sv
module eraseDatapath
  import spiErasePkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int MEM_ADDR_BITS = 24,
  parameter int SECTOR_BITS   = 16,
  parameter int CLK_DIV       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] addrIn,
  output dpStat_t           stat,
  output logic              spiCsN,
  output logic              spiSck,
  output logic              spiMosi,
  input  logic              spiMiso
);

  localparam int HALF   = CLK_DIV / 2;
  localparam int DIV_W  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int SR_W   = ADDR_W + 8;
  localparam int BIT_W  = $clog2(SR_W + 1);

  logic [ADDR_W-1:0] addrReg;
  logic [SR_W-1:0]   shiftReg;
  logic [BIT_W-1:0]  bitsLeft;
  logic [DIV_W-1:0]  divCnt;
  logic              active;
  logic              sckReg;
  logic [4:0]        rxBits;   // last five bits received: status[4:0]
  logic              halfTick;

  function automatic logic isProtected(input logic [2:0] bpField,
                                       input logic [MEM_ADDR_BITS-1:0] a);
    int k;
    logic [MEM_ADDR_BITS-1:0] topMask;
    if (bpField == 3'd0) return 1'b0;
    k = SECTOR_BITS + int'(bpField) - 1;
    if (k >= MEM_ADDR_BITS) return 1'b1;
    topMask = {MEM_ADDR_BITS{1'b1}} << k;
    return (a & topMask) == topMask;
  endfunction

  assign halfTick = (divCnt == DIV_W'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      shiftReg <= '0;
      bitsLeft <= '0;
      divCnt   <= '0;
      active   <= 1'b0;
      sckReg   <= 1'b0;
      rxBits   <= '0;
    end else begin
      if (cmd.latchAddr) addrReg <= addrIn;
      if (cmd.start) begin
        active <= 1'b1;
        sckReg <= 1'b0;
        divCnt <= '0;
        unique case (cmd.kind)
          FR_STATUS: begin
            shiftReg <= {OP_READ_STATUS, {ADDR_W{1'b0}}};
            bitsLeft <= BIT_W'(16);
          end
          FR_WREN: begin
            shiftReg <= {OP_WRITE_EN, {ADDR_W{1'b0}}};
            bitsLeft <= BIT_W'(8);
          end
          default: begin
            shiftReg <= {OP_SECT_ERASE, addrReg};
            bitsLeft <= BIT_W'(SR_W);
          end
        endcase
      end else if (active) begin
        if (halfTick) begin
          divCnt <= '0;
          if (!sckReg) begin
            sckReg <= 1'b1;
            rxBits <= {rxBits[3:0], spiMiso};
          end else begin
            sckReg   <= 1'b0;
            shiftReg <= shiftReg << 1;
            bitsLeft <= bitsLeft - 1'b1;
            if (bitsLeft == BIT_W'(1)) active <= 1'b0;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign spiCsN  = ~active;
  assign spiSck  = sckReg;
  assign spiMosi = active & shiftReg[SR_W-1];

  assign stat.frameDone = active && halfTick && sckReg && (bitsLeft == BIT_W'(1));
  assign stat.wip       = rxBits[0];
  assign stat.protHit   = isProtected(rxBits[4:2], addrReg[MEM_ADDR_BITS-1:0]);

endmodule

// File: rtl/eraseCtrl.sv
module eraseCtrl
  import spiErasePkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    eraseReq,
  input  logic    wrEn,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    busy,
  output logic    illegalErase
);

  seqState_t state;
  logic      holdCnt;
  logic      request;

  assign request = eraseReq && wrEn;

  always_comb begin
    cmd = '0;
    unique case (state)
      ST_IDLE:  cmd.latchAddr = request;
      ST_RDSR:  begin cmd.start = 1'b1; cmd.kind = FR_STATUS; end
      ST_WREN:  begin cmd.start = 1'b1; cmd.kind = FR_WREN;   end
      ST_ERASE: begin cmd.start = 1'b1; cmd.kind = FR_ERASE;  end
      ST_POLL:  begin cmd.start = 1'b1; cmd.kind = FR_STATUS; end
      default:  cmd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      holdCnt <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:  if (request) state <= ST_RDSR;
        ST_RDSR:  state <= ST_CHECK;
        ST_CHECK: if (stat.frameDone) begin
          holdCnt <= 1'b0;
          state   <= stat.protHit ? ST_REFUSE : ST_WREN;
        end
        ST_WREN:       state <= ST_WREN_WAIT;
        ST_WREN_WAIT:  if (stat.frameDone) state <= ST_ERASE;
        ST_ERASE:      state <= ST_ERASE_WAIT;
        ST_ERASE_WAIT: if (stat.frameDone) state <= ST_POLL;
        ST_POLL:       state <= ST_POLL_WAIT;
        ST_POLL_WAIT: if (stat.frameDone) begin
          holdCnt <= 1'b0;
          state   <= stat.wip ? ST_POLL : ST_COOL;
        end
        ST_COOL, ST_REFUSE: begin
          holdCnt <= 1'b1;
          if (holdCnt) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE) && (state != ST_COOL) && (state != ST_REFUSE);
  assign illegalErase = (state == ST_REFUSE);

endmodule

// File: rtl/spiSectorEraser.sv
module spiSectorEraser
  import spiErasePkg::*;
#(
  parameter bit ADDR_4B       = 1'b0,
  parameter int CLK_DIV       = 4,
  parameter int SECTOR_BITS   = 16,
  parameter int MEM_ADDR_BITS = 24,
  localparam int ADDR_W       = ADDR_4B ? 32 : 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eraseReq,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              illegalErase,
  output logic              spiCsN,
  output logic              spiSck,
  output logic              spiMosi,
  input  logic              spiMiso
);

  dpCmd_t  cmd;
  dpStat_t stat;

  eraseCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .eraseReq     (eraseReq),
    .wrEn         (wrEn),
    .stat         (stat),
    .cmd          (cmd),
    .busy         (busy),
    .illegalErase (illegalErase)
  );

  eraseDatapath #(
    .ADDR_W        (ADDR_W),
    .MEM_ADDR_BITS (MEM_ADDR_BITS),
    .SECTOR_BITS   (SECTOR_BITS),
    .CLK_DIV       (CLK_DIV)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .addrIn  (addr),
    .stat    (stat),
    .spiCsN  (spiCsN),
    .spiSck  (spiSck),
    .spiMosi (spiMosi),
    .spiMiso (spiMiso)
  );

endmodule

// File: rtl/eraseChecker.sv
module eraseChecker (
  input logic clk,
  input logic rstN,
  input logic eraseReq,
  input logic wrEn,
  input logic busy,
  input logic illegalErase,
  input logic spiCsN,
  input logic spiSck,
  input logic spiMosi
);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(eraseReq && wrEn));

  assert_idle_bus_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> spiCsN);

  assert_sck_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);

  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (spiSck && $past(spiSck)) |-> $stable(spiMosi));

  assert_pulse_two_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(illegalErase) |=> illegalErase);

  assert_pulse_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    (illegalErase && $past(illegalErase)) |=> !illegalErase);

  assert_refuse_origin_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(illegalErase) |-> $past(busy));

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && illegalErase));

  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |=> !busy ##1 !busy);

endmodule

bind spiSectorEraser eraseChecker uChk (
  .clk          (clk),
  .rstN         (rstN),
  .eraseReq     (eraseReq),
  .wrEn         (wrEn),
  .busy         (busy),
  .illegalErase (illegalErase),
  .spiCsN       (spiCsN),
  .spiSck       (spiSck),
  .spiMosi      (spiMosi)
);

// File: tb/tb_spiSectorEraser.sv
module flashModel #(parameter int AW = 24) (
  input  logic        csN,
  input  logic        sck,
  input  logic        mosi,
  output logic        miso,
  input  logic [2:0]  bp,
  input  int          wipPolls,
  output int          eraseCount,
  output int          frameCount,
  output int          badFrames,
  output logic [31:0] lastAddr
);
  logic [63:0] sr;
  int          nb;
  logic [7:0]  op;
  logic        wel;
  int          wip;
  logic [7:0]  statusVal;

  initial begin
    miso = 0; eraseCount = 0; frameCount = 0; badFrames = 0; lastAddr = 0;
    sr = 0; nb = 0; op = 0; wel = 0; wip = 0;
  end

  always @(negedge csN) begin sr = 0; nb = 0; op = 0; end

  always @(posedge sck) if (csN === 1'b0) begin
    sr = {sr[62:0], mosi};
    nb++;
    if (nb == 8) op = sr[7:0];
  end

  always @(negedge sck) if (csN === 1'b0 && nb >= 8 && nb < 16 && op == 8'h05) begin
    statusVal = {3'b000, bp, wel, (wip > 0)};
    miso = statusVal[15 - nb];
  end

  always @(posedge csN) if (nb > 0) begin
    frameCount++;
    case (op)
      8'h05: if (nb != 16) badFrames++; else if (wip > 0) wip--;
      8'h06: if (nb != 8) badFrames++; else wel = 1;
      8'hD8: if (nb != 8 + AW || !wel) badFrames++;
             else begin
               eraseCount++;
               lastAddr = 32'(sr[AW-1:0]);
               wel = 0;
               wip = wipPolls;
             end
      default: badFrames++;
    endcase
    nb = 0;
  end
endmodule

module tb_spiSectorEraser;
  localparam int DIV = 4;
  localparam int AW  = 24;

  logic clk = 0;
  logic rstN = 0;
  always #5 clk = ~clk;

  logic        eraseReq = 0, wrEn = 0;
  logic [23:0] addr = 0;
  logic        busy, illegalErase, spiCsN, spiSck, spiMosi, spiMiso;
  logic [2:0]  bp = 0;
  int          wipPolls = 0;
  int          eraseCount, frameCount, badFrames;
  logic [31:0] lastAddr;

  logic        eraseReq4 = 0, wrEn4 = 0;
  logic [31:0] addr4 = 0;
  logic        busy4, illegal4, cs4, sck4, mosi4, miso4;
  int          erase4, frames4, bad4;
  logic [31:0] last4;

  int compared = 0, mismatched = 0;

  spiSectorEraser #(.ADDR_4B(1'b0), .CLK_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .eraseReq(eraseReq), .wrEn(wrEn), .addr(addr),
    .busy(busy), .illegalErase(illegalErase), .spiCsN(spiCsN), .spiSck(spiSck),
    .spiMosi(spiMosi), .spiMiso(spiMiso));

  flashModel #(.AW(24)) flash (
    .csN(spiCsN), .sck(spiSck), .mosi(spiMosi), .miso(spiMiso), .bp(bp),
    .wipPolls(wipPolls), .eraseCount(eraseCount), .frameCount(frameCount),
    .badFrames(badFrames), .lastAddr(lastAddr));

  spiSectorEraser #(.ADDR_4B(1'b1), .CLK_DIV(DIV), .MEM_ADDR_BITS(32)) dut4 (
    .clk(clk), .rstN(rstN), .eraseReq(eraseReq4), .wrEn(wrEn4), .addr(addr4),
    .busy(busy4), .illegalErase(illegal4), .spiCsN(cs4), .spiSck(sck4),
    .spiMosi(mosi4), .spiMiso(miso4));

  flashModel #(.AW(32)) flash4 (
    .csN(cs4), .sck(sck4), .mosi(mosi4), .miso(miso4), .bp(3'b000),
    .wipPolls(1), .eraseCount(erase4), .frameCount(frames4),
    .badFrames(bad4), .lastAddr(last4));

  task automatic check(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: protection and busy length from the requirements
  function automatic bit benchProt(input logic [2:0] b, input logic [23:0] a);
    longint size;
    if (b == 0) return 0;
    size = 64'd1 << (16 + b - 1);
    if (size >= 64'd1 << 24) return 1;
    return longint'(a) >= (64'd1 << 24) - size;
  endfunction

  function automatic int busyLen(input bit prot, input int polls);
    if (prot) return 16*DIV + 1;
    return (16*DIV + 1) + (8*DIV + 1) + ((8 + AW)*DIV + 1) + (polls + 1)*(16*DIV + 1);
  endfunction

  int mLeft = 0, mIgn = 0;
  bit mRef = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mLeft = 0; mIgn = 0; mRef = 0;
    end else if (mLeft > 0) begin
      mLeft--;
      if (mLeft == 0) mIgn = 2;
    end else if (mIgn > 0) begin
      mIgn--;
    end else if (eraseReq && wrEn) begin
      mRef  = benchProt(bp, addr);
      mLeft = busyLen(mRef, wipPolls);
    end
  end

  int illCycles = 0;
  always @(negedge clk) if (rstN) begin
    check("R2/R5 busy vs model", busy, mLeft > 0);
    check("R6 illegalErase vs model", illegalErase, (mIgn > 0) && mRef);
    if (illegalErase) illCycles++;
  end

  // serial clock period inside a frame
  int lastRise = -1, minGap = 1 << 30, maxGap = 0;
  always @(negedge spiCsN) lastRise = -1;
  always @(posedge spiSck) begin
    if (lastRise >= 0) begin
      if (cyc - lastRise < minGap) minGap = cyc - lastRise;
      if (cyc - lastRise > maxGap) maxGap = cyc - lastRise;
    end
    lastRise = cyc;
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy || illegalErase) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic runErase(input logic [23:0] a);
    addr = a; eraseReq = 1; wrEn = 1;
    do @(negedge clk); while (!busy);
    eraseReq = 0; wrEn = 0;
    waitIdle();
  endtask

  initial begin
    #1_500_000;
    check("watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int e0, f0, i0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 illegalErase", illegalErase, 0);
    check("R1 spiCsN", spiCsN, 1);
    check("R1 spiSck", spiSck, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 spiCsN after release", spiCsN, 1);

    // normal erase, three busy polls
    wipPolls = 3; bp = 0;
    e0 = eraseCount; f0 = frameCount;
    runErase(24'h12_3456);
    check("R4 erase count", eraseCount, e0 + 1);
    check("R4 erase address", lastAddr, 32'h0012_3456);
    check("R4 frame errors", badFrames, 0);
    check("R5 frames incl polls", frameCount, f0 + 3 + 4);
    check("R11 sck min period", minGap, DIV);
    check("R11 sck max period", maxGap, DIV);

    // R3 strobe without qualifier and the reverse
    f0 = frameCount;
    eraseReq = 1; wrEn = 0; repeat (6) @(negedge clk);
    eraseReq = 0; wrEn = 1; repeat (6) @(negedge clk);
    wrEn = 0; repeat (2) @(negedge clk);
    check("R3 no frames", frameCount, f0);
    check("R3 busy low", busy, 0);

    // R6/R7 protected top sector with field 1
    wipPolls = 0; bp = 3'd1;
    e0 = eraseCount; f0 = frameCount; i0 = illCycles;
    runErase(24'hFF_0010);
    check("R6 only status frame", frameCount, f0 + 1);
    check("R6 no erase", eraseCount, e0);
    check("R6 pulse length", illCycles - i0, 2);

    // R7 just below the protected area
    e0 = eraseCount;
    runErase(24'hFE_FFFF);
    check("R7 field 1 below boundary", eraseCount, e0 + 1);
    check("R7 address", lastAddr, 32'h00FE_FFFF);

    // R7 field 2 covers two sectors
    bp = 3'd2; e0 = eraseCount;
    runErase(24'hFE_0000);
    check("R7 field 2 protected", eraseCount, e0);

    // R7 field 7 covers top 4 MiB
    bp = 3'd7; e0 = eraseCount;
    runErase(24'hC0_0000);
    check("R7 field 7 protected", eraseCount, e0);
    runErase(24'hBF_FFFF);
    check("R7 field 7 unprotected", eraseCount, e0 + 1);

    // R9 held request starts a second erase
    bp = 0; wipPolls = 1; e0 = eraseCount;
    addr = 24'h00_1234; eraseReq = 1; wrEn = 1;
    do @(negedge clk); while (!busy);
    do @(negedge clk); while (busy);
    do @(negedge clk); while (!busy);
    eraseReq = 0; wrEn = 0;
    waitIdle();
    check("R9 two erases from held request", eraseCount, e0 + 2);

    // R8 request only inside the ignore window
    e0 = eraseCount;
    addr = 24'h05_0000; eraseReq = 1; wrEn = 1;
    do @(negedge clk); while (!busy);
    eraseReq = 0; wrEn = 0;
    do @(negedge clk); while (busy);
    eraseReq = 1; wrEn = 1;
    repeat (2) @(negedge clk);
    eraseReq = 0; wrEn = 0;
    repeat (3) @(negedge clk);
    check("R8 no busy after window request", busy, 0);
    waitIdle();
    check("R8 single erase", eraseCount, e0 + 1);

    // R10 four-byte address variant
    addr4 = 32'h0123_4567; eraseReq4 = 1; wrEn4 = 1;
    do @(negedge clk); while (!busy4);
    eraseReq4 = 0; wrEn4 = 0;
    @(negedge clk);
    while (busy4) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R10 erase count", erase4, 1);
    check("R10 32-bit address", last4, 32'h0123_4567);
    check("R10 frame errors", bad4, 0);

    finishRun();
  end
endmodule